// File: doc/BRIEF.md
# PHY Bring-up Reset and PLL-Lock Sequencer

This block runs the serial-link PHY bring-up in hardware. It sits above a control-port handshake master, which turns each command it receives into the PHY's address, write and read cycles and returns one response per command. On a start pulse the sequencer resets the PHY. It sends an address command to the PHY clock/reset register at 0x7F3F, then a write of 0x0001, which sets the reset control in bit 0.

After the reset write it polls the lane output-status register at PHY address 0x2003. Before each poll it waits a fixed number of clock cycles. It then sends an address command to 0x2003 and a read command. The read result is tested for receive-PLL-stable, which is bit 1. Polling stops as soon as that bit is set, or after a bounded number of polls. If the handshake master reports a failure on any command, the sequence aborts at once.

The block reports its progress on busy, and its outcome as a one-cycle done pulse with an error flag. The wait is a parameter measured in clock cycles; its default is about 150 µs at 125 MHz. The poll limit is also a parameter, and defaults to 10.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset, busy_o, done_o, error_o and cmd_valid_o are all low.
- R2: A start_i pulse seen while idle raises busy_o in the next cycle. In that same cycle the block issues its first command: cmd_op_o = 0 (address) with cmd_data_o = 0x7F3F.
- R3: When the response to that address command arrives without error, the next cycle issues cmd_op_o = 1 (write) with cmd_data_o = 0x0001.
- R4: After an error-free response to the reset write, or to a poll read that neither locks nor ends the sequence, exactly DELAY_CYC cycles pass with no command. The next cycle then issues cmd_op_o = 0 with cmd_data_o = 0x2003.
- R5: After an error-free response to a poll address command, the next cycle issues cmd_op_o = 2 (read) with cmd_data_o = 0x0000. If the read data has bit 1 set, the sequence ends with done_o and error_o low in the cycle after the response. All other read-data bits are ignored.
- R6: At most MAX_POLLS address/read polls are made. If the MAX_POLLS-th read returns bit 1 clear, done_o rises with error_o high in the next cycle and no further command is issued.
- R7: A response with rsp_err_i high, to any command, ends the sequence in the next cycle with done_o and error_o high and no further command.
- R8: done_o is a single-cycle pulse. error_o is high only together with done_o. busy_o is low in the done cycle and in every cycle after it until the next start.
- R9: start_i while busy has no effect on the command stream or on the timing of the outcome.
- R10: Each accepted start restarts the poll count, so a run after a timed-out run again gets the full MAX_POLLS polls.
- R11: Each command is presented on cmd_valid_o for exactly one cycle. No other command follows until its response has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for the bring-up sequence |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Failure flag, valid with done_o |
| cmd_valid_o | output | 1 | One-cycle command strobe to the handshake master |
| cmd_op_o | output | 2 | Command kind: 0 address, 1 write, 2 read |
| cmd_data_o | output | 16 | PHY address or write data |
| rsp_valid_i | input | 1 | Response strobe from the handshake master |
| rsp_err_i | input | 1 | Handshake failure, valid with rsp_valid_i |
| rsp_rdata_i | input | 16 | Read data, valid with rsp_valid_i |

## Verification
The bench compares every output, every cycle, against a timeline that a scripted responder derives from the response latency. Off-by-one delay counting shows up as a poll address one cycle early or late. A poll limit of nine or eleven shows up as a wrong number of polls before the timeout. Error injection on the reset address, on the reset write and on a mid-run poll read catches a sequencer that continues after a handshake failure. Read data with every bit set except bit 1 catches a lock test on the wrong bit. A start inside a run catches a block that restarts. A run right after a timeout catches a poll count that is not cleared.

// File: rtl/physeq_pkg.sv
package physeq_pkg;
  localparam int PHY_DW = 16;

  localparam logic [PHY_DW-1:0] CLKRST_ADDR   = 16'h7F3F;
  localparam logic [PHY_DW-1:0] LANESTAT_ADDR = 16'h2003;
  localparam int                RST_BIT       = 0;
  localparam int                LOCK_BIT      = 1;
  localparam logic [PHY_DW-1:0] RESET_VAL     = PHY_DW'(1) << RST_BIT;
  localparam logic [PHY_DW-1:0] LOCK_MASK     = PHY_DW'(1) << LOCK_BIT;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DELAY
  } st_e;

  typedef enum logic [1:0] {
    STEP_RST_ADDR,
    STEP_RST_WR,
    STEP_POLL_ADDR,
    STEP_POLL_RD
  } step_e;

  typedef struct packed {
    op_e              op;
    logic [PHY_DW-1:0] data;
  } cmd_t;

  function automatic cmd_t step_cmd(step_e s);
    cmd_t c;
    case (s)
      STEP_RST_ADDR:  c = '{op: OP_ADDR,  data: CLKRST_ADDR};
      STEP_RST_WR:    c = '{op: OP_WRITE, data: RESET_VAL};
      STEP_POLL_ADDR: c = '{op: OP_ADDR,  data: LANESTAT_ADDR};
      default:        c = '{op: OP_READ,  data: '0};
    endcase
    return c;
  endfunction

  function automatic logic pll_locked(logic [PHY_DW-1:0] rdata);
    return |(rdata & LOCK_MASK);
  endfunction
endpackage

// File: rtl/physeq_delay.sv
module physeq_delay #(
  parameter int DELAY_CYC = 18750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = $clog2(DELAY_CYC + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(DELAY_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (load_i)               cnt <= LOAD_VAL;
    else if (run_i && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired_o = run_i && (cnt == '0);

  AST_DELAY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LOAD_VAL); // R4
  AST_LOAD_NOT_EXPIRED: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (DELAY_CYC == 1) || !expired_o); // R4
endmodule

// File: rtl/physeq_polls.sv
module physeq_polls #(
  parameter int MAX_POLLS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic step_i,
  output logic last_o
);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam logic [PW-1:0] LIMIT = PW'(MAX_POLLS);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (clear_i)                cnt <= '0;
    else if (step_i && cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign last_o = (cnt == LIMIT);

  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIMIT); // R6
  AST_NO_STEP_PAST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> !step_i); // R6
endmodule

// File: rtl/physeq_fsm.sv
module physeq_fsm
  import physeq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rsp_valid_i,
  input  logic              rsp_err_i,
  input  logic [PHY_DW-1:0] rsp_rdata_i,
  input  logic              delay_expired_i,
  input  logic              polls_last_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic              cmd_valid_o,
  output op_e               cmd_op_o,
  output logic [PHY_DW-1:0] cmd_data_o,
  output logic              delay_load_o,
  output logic              delay_run_o,
  output logic              poll_clear_o,
  output logic              poll_step_o
);
  st_e   state;
  step_e step;
  cmd_t  cur_cmd;

  // Named events for the assertions and the helper counters
  logic ev_start, ev_rsp_ok, ev_hs_fail, ev_lock, ev_exhausted;
  logic ev_finish_ok, ev_finish_err;

  assign ev_start      = (state == ST_IDLE) && start_i;
  assign ev_rsp_ok     = (state == ST_WAIT) && rsp_valid_i && !rsp_err_i;
  assign ev_hs_fail    = (state == ST_WAIT) && rsp_valid_i && rsp_err_i;
  assign ev_lock       = ev_rsp_ok && (step == STEP_POLL_RD) && pll_locked(rsp_rdata_i);
  assign ev_exhausted  = ev_rsp_ok && (step == STEP_POLL_RD) && !pll_locked(rsp_rdata_i)
                         && polls_last_i;
  assign ev_finish_ok  = ev_lock;
  assign ev_finish_err = ev_hs_fail || ev_exhausted;

  assign delay_load_o = ev_rsp_ok && ((step == STEP_RST_WR) ||
                        ((step == STEP_POLL_RD) && !ev_lock && !ev_exhausted));
  assign delay_run_o  = (state == ST_DELAY);
  assign poll_clear_o = ev_start;
  assign poll_step_o  = (state == ST_DELAY) && delay_expired_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      step    <= STEP_RST_ADDR;
      done_o  <= 1'b0;
      error_o <= 1'b0;
    end else begin
      done_o  <= ev_finish_ok || ev_finish_err;
      error_o <= ev_finish_err;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            state <= ST_ISSUE;
            step  <= STEP_RST_ADDR;
          end
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: begin
          if (ev_finish_ok || ev_finish_err) begin
            state <= ST_IDLE;
          end else if (delay_load_o) begin
            state <= ST_DELAY;
          end else if (ev_rsp_ok) begin
            state <= ST_ISSUE;
            step  <= (step == STEP_RST_ADDR) ? STEP_RST_WR : STEP_POLL_RD;
          end
        end
        default: begin
          if (delay_expired_i) begin
            state <= ST_ISSUE;
            step  <= STEP_POLL_ADDR;
          end
        end
      endcase
    end
  end

  assign cur_cmd     = step_cmd(step);
  assign cmd_valid_o = (state == ST_ISSUE);
  assign cmd_op_o    = cur_cmd.op;
  assign cmd_data_o  = cur_cmd.data;
  assign busy_o      = (state != ST_IDLE);

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && cmd_valid_o)); // R2
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && start_i) |=> (busy_o && !cmd_valid_o)); // R9
  AST_ONE_CYCLE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o); // R11
  AST_FAIL_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && rsp_valid_i && rsp_err_i) |=> (done_o && error_o && !busy_o)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> done_o); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R8
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import physeq_pkg::*;
#(
  parameter int DELAY_CYC = 18750,
  parameter int MAX_POLLS = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        error_o,
  output logic        cmd_valid_o,
  output logic [1:0]  cmd_op_o,
  output logic [15:0] cmd_data_o,
  input  logic        rsp_valid_i,
  input  logic        rsp_err_i,
  input  logic [15:0] rsp_rdata_i
);
  logic delay_load, delay_run, delay_expired;
  logic poll_clear, poll_step, polls_last;
  op_e  cmd_op;

  physeq_fsm u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .rsp_valid_i     (rsp_valid_i),
    .rsp_err_i       (rsp_err_i),
    .rsp_rdata_i     (rsp_rdata_i),
    .delay_expired_i (delay_expired),
    .polls_last_i    (polls_last),
    .busy_o          (busy_o),
    .done_o          (done_o),
    .error_o         (error_o),
    .cmd_valid_o     (cmd_valid_o),
    .cmd_op_o        (cmd_op),
    .cmd_data_o      (cmd_data_o),
    .delay_load_o    (delay_load),
    .delay_run_o     (delay_run),
    .poll_clear_o    (poll_clear),
    .poll_step_o     (poll_step)
  );

  physeq_delay #(.DELAY_CYC(DELAY_CYC)) u_delay (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (delay_load),
    .run_i     (delay_run),
    .expired_o (delay_expired)
  );

  physeq_polls #(.MAX_POLLS(MAX_POLLS)) u_polls (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (poll_clear),
    .step_i  (poll_step),
    .last_o  (polls_last)
  );

  assign cmd_op_o = cmd_op;
endmodule

// File: tb/phy_bringup_seq_tb.sv
`timescale 1ns/1ps
module phy_bringup_seq_tb;
  localparam int D  = 8;
  localparam int MP = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic busy_o, done_o, error_o, cmd_valid_o;
  logic [1:0]  cmd_op_o;
  logic [15:0] cmd_data_o;
  logic        rsp_valid_i = 1'b0;
  logic        rsp_err_i = 1'b0;
  logic [15:0] rsp_rdata_i = 16'h0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  phy_bringup_seq #(.DELAY_CYC(D), .MAX_POLLS(MP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .busy_o(busy_o), .done_o(done_o), .error_o(error_o),
    .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o), .cmd_data_o(cmd_data_o),
    .rsp_valid_i(rsp_valid_i), .rsp_err_i(rsp_err_i), .rsp_rdata_i(rsp_rdata_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference timeline: commands at computed cycles; responder answers lat cycles after each.
  task automatic run_case(input string req, input int lat, input int lock_at,
                          input int fail_idx, input int mid_start);
    int et[$]; int eo[$]; int ed[$];
    int t = 0; int endt = 0; bit eerr = 0; bit fin = 0;
    int rsp_at = -1; bit perr = 0; logic [15:0] prd = 16'h0;
    int nrd = 0; int kseen = 0; int qi = 0;

    et.push_back(0); eo.push_back(0); ed.push_back(16'h7F3F);
    if (fail_idx == 0) begin endt = lat + 1; eerr = 1; fin = 1; end
    if (!fin) begin
      t += lat + 1;
      et.push_back(t); eo.push_back(1); ed.push_back(16'h0001);
      if (fail_idx == 1) begin endt = t + lat + 1; eerr = 1; fin = 1; end
    end
    for (int p = 1; p <= MP && !fin; p++) begin
      t += lat + 1 + D;
      et.push_back(t); eo.push_back(0); ed.push_back(16'h2003);
      if (fail_idx == 2*p) begin endt = t + lat + 1; eerr = 1; fin = 1; end
      else begin
        t += lat + 1;
        et.push_back(t); eo.push_back(2); ed.push_back(16'h0000);
        if (fail_idx == 2*p + 1) begin endt = t + lat + 1; eerr = 1; fin = 1; end
        else if (p == lock_at)  begin endt = t + lat + 1; eerr = 0; fin = 1; end
        else if (p == MP)       begin endt = t + lat + 1; eerr = 1; fin = 1; end
      end
    end

    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    for (int c = 0; c <= endt + 3; c++) begin
      bit ecv;
      rsp_valid_i = (c == rsp_at);
      rsp_err_i   = perr;
      rsp_rdata_i = prd;
      start_i     = (c == mid_start);
      ecv = (qi < et.size()) && (et[qi] == c);
      chk(cmd_valid_o == ecv, req, $sformatf("cmd_valid c=%0d", c), cmd_valid_o, ecv);
      chk(busy_o == (c < endt), req, $sformatf("busy c=%0d", c), busy_o, c < endt);
      chk(done_o == (c == endt), req, $sformatf("done c=%0d", c), done_o, c == endt);
      chk(error_o == ((c == endt) && eerr), req, $sformatf("error c=%0d", c),
          error_o, (c == endt) && eerr);
      if (ecv) begin
        chk(cmd_op_o == eo[qi], req, $sformatf("cmd_op c=%0d", c), cmd_op_o, eo[qi]);
        chk(cmd_data_o == ed[qi], req, $sformatf("cmd_data c=%0d", c), cmd_data_o, ed[qi]);
        qi++;
      end
      if (cmd_valid_o) begin
        rsp_at = c + lat;
        perr   = (kseen == fail_idx);
        if (cmd_op_o == 2'd2) begin
          nrd++;
          prd = (nrd == lock_at) ? 16'h0002 : 16'hFFFD;
        end
        kseen++;
      end
      @(negedge clk);
    end
    start_i = 1'b0; rsp_valid_i = 1'b0; rsp_err_i = 1'b0;
    chk(qi == et.size(), req, "commands seen", qi, et.size());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy_o, "R1", "busy after reset", busy_o, 0);
    chk(!done_o, "R1", "done after reset", done_o, 0);
    chk(!error_o, "R1", "error after reset", error_o, 0);
    chk(!cmd_valid_o, "R1", "cmd_valid after reset", cmd_valid_o, 0);
    // Lock on first poll (R2 R3 R4 R5 R8 R11)
    run_case("R2 R3 R4 R5 R8 R11", 1, 1, -1, -1);
    // Slower responder, lock on poll 4, start during run (R5 R9)
    run_case("R5 R9", 3, 4, -1, 5);
    // Start while in the delay window (R9 R4)
    run_case("R9 R4", 2, 2, -1, 12);
    // Never locks: timeout after the poll limit (R6)
    run_case("R6", 2, 0, -1, -1);
    // Right after a timeout: full poll budget again, lock on last poll (R10)
    run_case("R10 R6", 1, MP, -1, -1);
    // Handshake failures at several points (R7)
    run_case("R7 addr", 1, 1, 0, -1);
    run_case("R7 write", 2, 1, 1, -1);
    run_case("R7 poll read", 2, 5, 5, -1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule